// File: doc/BRIEF.md
# Banked GPIO Controller with Pin Interrupts

This block is a register-mapped general-purpose I/O controller for up to 94 pads, accessed over a plain 32-bit register read/write port. Each pin owns two configuration words: the first carries its output level, its sampled input level, its direction, its mode select and a two-bit interrupt trigger type; the second carries an input-disable control and a two-bit pull field. Grouped 32 pins to a bank, three word groups hold the software-ownership flags, the sticky interrupt status and the interrupt enables.

Pad inputs are resynchronised through two flops and compared with their previous sample. Each pin's trigger type picks a rising edge, a falling edge, a low level or a high level. A matching event latches the pin's status bit, and a single interrupt line goes high while any enabled status bit is set. Software clears status by writing ones to it.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset all status and enable bits are 0, every pin is an input (first word reads 0x00000005), every input disable is set (second word reads 0x00000004), and irq_out is 0.
- R2: Bank words sit at 0x00 (ownership), 0x80 (status) and 0x90 (enable) plus 4 per bank of 32 pins. The first config word of pin p is at 0x100 + 8p and the second at 0x104 + 8p.
- R3: First config word fields: bit 31 output level, bit 4 trigger select, bit 3 invert, bit 2 direction (1 input, 0 output), bit 0 mode select. pad_out follows bit 31 and pad_oe is high when bit 2 is 0.
- R4: Bit 30 of the first word reads the pad level through a two-flop synchronizer. Writes to it have no effect, and it reads 0 while input disable is set.
- R5: With (select, invert) = 00 a rising pad edge sets the pin's status bit, and with 01 a falling edge does. The bit stays set until it is cleared.
- R6: With (select, invert) = 10 a low level and with 11 a high level set the status bit on every cycle the level holds, so a clear does not stick while it lasts.
- R7: Writing 1 to a status bit clears it and writing 0 leaves it unchanged.
- R8: irq_out is 1 exactly when some bank has a bit set in both status and enable. A status bit whose enable is 0 does not raise it.
- R9: Bit 2 of the second word is input disable. While it is set, pad activity raises no status. Bits 1:0 are a read/write pull field.
- R10: Ownership words are read-only and read 1 for every existing pin and 0 above the last pin.
- R11: Reads of unmapped addresses return 0.
- R12: Read data and reg_rvalid appear on the cycle after a read request. reg_rvalid is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 1 | Register access request |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data |
| reg_rvalid | output | 1 | Read data valid |
| pad_in | input | 94 | Pad input levels |
| pad_out | output | 94 | Pad output levels |
| pad_oe | output | 94 | Pad output enables |
| irq_out | output | 1 | Combined interrupt |

## Verification
A read returns its data one cycle after the request. The scoreboard queues each expected word when the request is driven and compares it on the falling edge at which reg_rvalid is high. A pad change reaches the input-level bit two cycles later. It reaches the status bit and irq_out three cycles later, so pad-driven checks wait four cycles before reading or sampling. Configuration writes take effect on pad_out and pad_oe at the next edge, and those ports are sampled on the following falling edge.

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl #(
  parameter int NPINS = 94,
  parameter int AW    = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_sel,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             reg_rvalid,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic             irq_out
);
  localparam int NB       = (NPINS + 31) / 32;
  localparam int BW       = NB * 32;
  localparam int BIW      = (NB > 1) ? $clog2(NB) : 1;
  localparam int PW       = $clog2(NPINS);
  localparam int OWN_BASE = 'h000;
  localparam int STS_BASE = 'h080;
  localparam int ENA_BASE = 'h090;
  localparam int CFG_BASE = 'h100;
  localparam int CFG_END  = CFG_BASE + 8 * NPINS;

  logic [NPINS-1:0] out_q, dir_q, mode_q, tsel_q, tinv_q, idis_q;
  logic [NPINS-1:0] pl0_q, pl1_q, sts_q, ena_q;
  logic [NPINS-1:0] s1_q, s2_q, s3_q, evt;
  logic [31:0]      rd_mux;

  wire rd_req  = reg_sel && !reg_wr;
  wire wr_req  = reg_sel && reg_wr;
  wire own_hit = reg_addr >= AW'(OWN_BASE) && reg_addr < AW'(OWN_BASE + 4 * NB);
  wire sts_hit = reg_addr >= AW'(STS_BASE) && reg_addr < AW'(STS_BASE + 4 * NB);
  wire ena_hit = reg_addr >= AW'(ENA_BASE) && reg_addr < AW'(ENA_BASE + 4 * NB);
  wire cfg_hit = reg_addr >= AW'(CFG_BASE) && reg_addr < AW'(CFG_END);
  wire [BIW-1:0] bidx  = reg_addr[BIW+1:2];
  wire [AW-1:0]  coff  = reg_addr - AW'(CFG_BASE);
  wire [PW-1:0]  pidx  = coff[PW+2:3];
  wire           word2 = reg_addr[2];

  wire [BW-1:0] own_pad = {{(BW-NPINS){1'b0}}, {NPINS{1'b1}}};
  wire [BW-1:0] sts_pad = {{(BW-NPINS){1'b0}}, sts_q};
  wire [BW-1:0] ena_pad = {{(BW-NPINS){1'b0}}, ena_q};

  assign pad_out = out_q;
  assign pad_oe  = ~dir_q;
  assign irq_out = |(sts_q & ena_q);

  assign evt = ~idis_q & ( (~tsel_q & ~tinv_q &  s2_q & ~s3_q)
                         | (~tsel_q &  tinv_q & ~s2_q &  s3_q)
                         | ( tsel_q & ~tinv_q & ~s2_q)
                         | ( tsel_q &  tinv_q &  s2_q) );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q <= '0; s2_q <= '0; s3_q <= '0;
    end else begin
      s1_q <= pad_in; s2_q <= s1_q; s3_q <= s2_q;
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    localparam int B = i / 32;
    localparam int K = i % 32;
    wire cfg_w = wr_req && cfg_hit && pidx == PW'(i);
    wire sclr  = wr_req && sts_hit && bidx == BIW'(B) && reg_wdata[K];
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        out_q[i] <= 1'b0; dir_q[i] <= 1'b1; mode_q[i] <= 1'b1;
        tsel_q[i] <= 1'b0; tinv_q[i] <= 1'b0; idis_q[i] <= 1'b1;
        pl0_q[i] <= 1'b0; pl1_q[i] <= 1'b0;
        sts_q[i] <= 1'b0; ena_q[i] <= 1'b0;
      end else begin
        if (cfg_w && !word2) begin
          out_q[i]  <= reg_wdata[31];
          tsel_q[i] <= reg_wdata[4];
          tinv_q[i] <= reg_wdata[3];
          dir_q[i]  <= reg_wdata[2];
          mode_q[i] <= reg_wdata[0];
        end
        if (cfg_w && word2) begin
          idis_q[i] <= reg_wdata[2];
          pl1_q[i]  <= reg_wdata[1];
          pl0_q[i]  <= reg_wdata[0];
        end
        if (wr_req && ena_hit && bidx == BIW'(B)) ena_q[i] <= reg_wdata[K];
        sts_q[i] <= (sts_q[i] & ~sclr) | evt[i];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (own_hit)      rd_mux = own_pad[{bidx, 5'b0} +: 32];
    else if (sts_hit) rd_mux = sts_pad[{bidx, 5'b0} +: 32];
    else if (ena_hit) rd_mux = ena_pad[{bidx, 5'b0} +: 32];
    else if (cfg_hit && !word2) begin
      rd_mux[31] = out_q[pidx];
      rd_mux[30] = s2_q[pidx] & ~idis_q[pidx];
      rd_mux[4]  = tsel_q[pidx];
      rd_mux[3]  = tinv_q[pidx];
      rd_mux[2]  = dir_q[pidx];
      rd_mux[0]  = mode_q[pidx];
    end else if (cfg_hit) begin
      rd_mux[2] = idis_q[pidx];
      rd_mux[1] = pl1_q[pidx];
      rd_mux[0] = pl0_q[pidx];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= rd_req;
      if (rd_req) reg_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_sel,
  input logic          reg_wr,
  input logic [AW-1:0] reg_addr,
  input logic [31:0]   reg_rdata,
  input logic          reg_rvalid
);
  assert_rvalid_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && !reg_wr) |=> reg_rvalid);
  assert_rvalid_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_sel && !reg_wr) |=> !reg_rvalid);
  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && !reg_wr && reg_addr >= AW'('h010) && reg_addr < AW'('h080)) |=> reg_rdata == 32'h0);
  assert_owner_first_bank_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && !reg_wr && reg_addr == AW'('h000)) |=> reg_rdata == 32'hFFFF_FFFF);
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid)
);

// File: tb/gpio_bank_ctrl_test.sv
module gpio_bank_ctrl_test;
  localparam int NP = 94;
  logic clk = 0, rst_n = 0;
  logic reg_sel = 0, reg_wr = 0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic reg_rvalid, irq_out;
  logic [NP-1:0] pad_in = '0, pad_out, pad_oe;
  int n_cmp = 0, n_bad = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  bit done = 0;

  always #2 clk = ~clk;

  gpio_bank_ctrl uut (.*);

  always @(negedge clk) if (reg_rvalid) begin
    if (exp_q.size() == 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R12: unexpected read data %h, expected none", reg_rdata);
    end else begin
      logic [31:0] e; string t;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      n_cmp++;
      if (reg_rdata !== e) begin
        n_bad++;
        $display("FAIL %s: read %h expected %h", t, reg_rdata, e);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_sel = 1; reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_sel = 0; reg_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    @(negedge clk); reg_sel = 1; reg_wr = 0; reg_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); reg_sel = 0;
  endtask

  task automatic chk(input logic a, input logic e, input string t);
    n_cmp++;
    if (a !== e) begin n_bad++; $display("FAIL %s: got %b expected %b", t, a, e); end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    idle(3); rst_n = 1; idle(1);
    chk(irq_out, 0, "R1 irq after reset");
    rd(12'h100, 32'h5, "R1 cfg1 pin0");
    rd(12'h104, 32'h4, "R1 cfg2 pin0");
    rd(12'h080, 32'h0, "R1 status bank0");
    rd(12'h098, 32'h0, "R1 enable bank2");
    rd(12'h000, 32'hFFFF_FFFF, "R10 owner bank0");
    rd(12'h008, 32'h3FFF_FFFF, "R10 owner bank2");
    wr(12'h000, 32'h0);
    rd(12'h000, 32'hFFFF_FFFF, "R10 owner write ignored");
    rd(12'h040, 32'h0, "R11 unmapped 0x40");
    rd(12'h3F0, 32'h0, "R11 unmapped past config");

    wr(12'h128, 32'hC000_0001);
    chk(pad_oe[5], 1, "R3 pad_oe pin5");
    chk(pad_out[5], 1, "R3 pad_out pin5");
    rd(12'h128, 32'h8000_0001, "R3 R4 cfg1 pin5 readback");
    wr(12'h12C, 32'h7);
    rd(12'h12C, 32'h7, "R9 pull field");

    pad_in[7] = 1; idle(4);
    rd(12'h138, 32'h5, "R4 level hidden while disabled");
    rd(12'h080, 32'h0, "R9 no status while disabled");
    wr(12'h13C, 32'h0); idle(3);
    rd(12'h138, 32'h4000_0005, "R4 level visible");
    rd(12'h080, 32'h0, "R9 enabling high pad is no edge");

    wr(12'h244, 32'h0);
    wr(12'h094, 32'h100);
    rd(12'h094, 32'h100, "R2 enable bank1 readback");
    pad_in[40] = 1; idle(4);
    chk(irq_out, 1, "R8 irq on enabled rising");
    rd(12'h084, 32'h100, "R5 rising status pin40");
    wr(12'h084, 32'h0);
    rd(12'h084, 32'h100, "R7 write zero keeps status");
    wr(12'h084, 32'hFFFF_FFFF); idle(1);
    chk(irq_out, 0, "R7 R8 irq after clear");
    rd(12'h084, 32'h0, "R7 status cleared");

    wr(12'h248, 32'hD);
    pad_in[41] = 1; idle(3);
    wr(12'h24C, 32'h0); idle(3);
    rd(12'h084, 32'h0, "R5 no event on rising for falling type");
    pad_in[41] = 0; idle(4);
    rd(12'h084, 32'h200, "R5 falling status pin41");
    chk(irq_out, 0, "R8 masked status no irq");

    wr(12'h330, 32'h1D);
    wr(12'h334, 32'h0);
    pad_in[70] = 1; idle(4);
    rd(12'h088, 32'h40, "R6 level high status");
    wr(12'h088, 32'h40);
    rd(12'h088, 32'h40, "R6 level high survives clear");
    pad_in[70] = 0; idle(4);
    wr(12'h088, 32'h40);
    rd(12'h088, 32'h0, "R6 level high cleared after release");

    pad_in[93] = 1;
    wr(12'h3E8, 32'h15);
    wr(12'h3EC, 32'h0);
    wr(12'h098, 32'h2000_0000); idle(4);
    rd(12'h088, 32'h0, "R6 level low idle");
    chk(irq_out, 0, "R8 no irq level low idle");
    pad_in[93] = 0; idle(4);
    chk(irq_out, 1, "R8 irq level low");
    rd(12'h088, 32'h2000_0000, "R6 level low status pin93");
    pad_in[93] = 1; idle(4);
    wr(12'h088, 32'hFFFF_FFFF); idle(1);
    chk(irq_out, 0, "R8 irq gone after release and clear");

    idle(3);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R12: %0d reads unanswered, expected 0", exp_q.size());
    end
    done = 1;
    finish_run();
  end
endmodule